// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block drives the unit current switches of a 10-bit current-steering DAC. On each clock edge it registers the binary input code. It then splits the registered code into three fields. The top field is decoded into a thermometer row of equal upper units. The next field is decoded into a thermometer row of smaller middle units, each one sixteenth of an upper unit. The bottom bit drives a single binary-weighted source worth half a middle unit. Every control leaves the block as a registered pair. The A-side bit steers its source to the A output node, and the complementary B-side bit steers it to the B node. Both bits of a pair are loaded on the same edge, so the two switches of a pair move together.

A sleep input parks the converter. While it is high, every A-side and B-side control is forced low and the input register holds its contents. A valid flag shows when the switch outputs first reflect a code taken from the input after reset. Field widths are parameters. The defaults are 5 upper bits (31 units), 4 middle bits (15 units) and 1 low bit.

Top module: `segdac_switch_decoder`

## Requirements
- R1: During and directly after a synchronous active-high reset, the captured code is 0, all A-side controls are 0, all B-side controls are 1, and the valid flag is 0.
- R2: On every rising edge with sleep low, the captured code output takes the value present on the data input.
- R3: The A-side upper row has bit i (bit 0 first) set exactly when i is below the value of code bits [9:5], so its popcount equals that field.
- R4: The A-side middle row has bit i (bit 0 first) set exactly when i is below the value of code bits [4:1].
- R5: The A-side low control equals code bit 0.
- R6: The A-side weight, 32 per upper unit + 2 per middle unit + 1 for the low control, equals the decoded code for all codes 0 to 1023.
- R7: Outside sleep, every B-side control is the inverse of its A-side partner, so the B-side weight equals 1023 minus the code.
- R8: The switch outputs reflect the captured code one rising edge after it was captured.
- R9: On any edge with sleep high, all A-side and B-side controls go to 0, the valid flag goes to 0, and the captured code holds its value.
- R10: On the first edge after sleep is released, the outputs decode the code held during sleep. The input present at that edge is captured and shows on the outputs one edge later.
- R11: After reset is released with sleep low, the valid flag is 0 after the first edge and 1 after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Parks all switches and freezes capture |
| din | input | 10 | Binary DAC code |
| code_out | output | 10 | Captured code |
| up_a | output | 31 | Upper unit controls, A side |
| up_b | output | 31 | Upper unit controls, B side |
| mid_a | output | 15 | Middle unit controls, A side |
| mid_b | output | 15 | Middle unit controls, B side |
| lsb_a | output | 1 | Binary low control, A side |
| lsb_b | output | 1 | Binary low control, B side |
| out_valid | output | 1 | Switch outputs reflect a captured input code |

## Verification
The bench builds the block with its default fields of 5, 4 and 1 bits. At that size an exhaustive pass over all 1024 codes costs only about two thousand cycles. This covers every thermometer level of both rows, including the empty row and the full row, together with both states of the low bit. It also checks the extremes 0 and 1023, where all weight sits on one node. Directed sequences around sleep entry and release show the frozen capture register and the one-edge handover between the held code and the new code.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DEF_UP_BITS  = 5;
  localparam int DEF_MID_BITS = 4;
  localparam int DEF_LSB_BITS = 1;

  function automatic int unit_count(input int bits);
    return (1 << bits) - 1;
  endfunction
endpackage

// File: rtl/segdac_capture.sv
module segdac_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic [W-1:0] din,
  output logic [W-1:0] code_q,
  output logic         cap_v
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      cap_v  <= 1'b0;
    end else if (!sleep) begin
      code_q <= din;
      cap_v  <= 1'b1;
    end
  end
endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
  parameter int BITS = 5,
  localparam int N   = (1 << BITS) - 1
) (
  input  logic [BITS-1:0] val,
  output logic [N-1:0]    therm
);
  for (genvar i = 0; i < N; i++) begin : g_unit
    assign therm[i] = (val > BITS'(i));
  end
endmodule

// File: rtl/segdac_retime.sv
module segdac_retime #(
  parameter int W = 47
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         cap_v,
  input  logic [W-1:0] dec,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b,
  output logic         q_v
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= '0;
      q_b <= '1;
      q_v <= 1'b0;
    end else if (sleep) begin
      q_a <= '0;
      q_b <= '0;
      q_v <= 1'b0;
    end else begin
      q_a <= dec;
      q_b <= ~dec;
      q_v <= cap_v;
    end
  end
endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder #(
  parameter int UP_BITS  = segdac_pkg::DEF_UP_BITS,
  parameter int MID_BITS = segdac_pkg::DEF_MID_BITS,
  parameter int LSB_BITS = segdac_pkg::DEF_LSB_BITS,
  localparam int CODE_W  = UP_BITS + MID_BITS + LSB_BITS,
  localparam int UP_N    = (1 << UP_BITS) - 1,
  localparam int MID_N   = (1 << MID_BITS) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code_out,
  output logic [UP_N-1:0]   up_a,
  output logic [UP_N-1:0]   up_b,
  output logic [MID_N-1:0]  mid_a,
  output logic [MID_N-1:0]  mid_b,
  output logic [LSB_BITS-1:0] lsb_a,
  output logic [LSB_BITS-1:0] lsb_b,
  output logic              out_valid
);
  localparam int ALL_N = UP_N + MID_N + LSB_BITS;

  logic              cap_v;
  logic [UP_N-1:0]   up_dec;
  logic [MID_N-1:0]  mid_dec;
  logic [ALL_N-1:0]  dec_all, reg_a, reg_b;

  segdac_capture #(.W(CODE_W)) u_cap (
    .clk(clk), .rst(rst), .sleep(sleep), .din(din),
    .code_q(code_out), .cap_v(cap_v)
  );

  segdac_therm #(.BITS(UP_BITS)) u_up (
    .val(code_out[CODE_W-1 -: UP_BITS]), .therm(up_dec)
  );

  segdac_therm #(.BITS(MID_BITS)) u_mid (
    .val(code_out[LSB_BITS +: MID_BITS]), .therm(mid_dec)
  );

  assign dec_all = {up_dec, mid_dec, code_out[LSB_BITS-1:0]};

  segdac_retime #(.W(ALL_N)) u_ret (
    .clk(clk), .rst(rst), .sleep(sleep), .cap_v(cap_v),
    .dec(dec_all), .q_a(reg_a), .q_b(reg_b), .q_v(out_valid)
  );

  assign up_a  = reg_a[ALL_N-1 -: UP_N];
  assign up_b  = reg_b[ALL_N-1 -: UP_N];
  assign mid_a = reg_a[LSB_BITS +: MID_N];
  assign mid_b = reg_b[LSB_BITS +: MID_N];
  assign lsb_a = reg_a[LSB_BITS-1:0];
  assign lsb_b = reg_b[LSB_BITS-1:0];
endmodule

// File: rtl/segdac_checker.sv
module segdac_checker #(
  parameter int UP_BITS  = 5,
  parameter int MID_BITS = 4,
  parameter int LSB_BITS = 1,
  localparam int CODE_W  = UP_BITS + MID_BITS + LSB_BITS,
  localparam int UP_N    = (1 << UP_BITS) - 1,
  localparam int MID_N   = (1 << MID_BITS) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic [CODE_W-1:0] din,
  input logic [CODE_W-1:0] code_out,
  input logic [UP_N-1:0]   up_a,
  input logic [UP_N-1:0]   up_b,
  input logic [MID_N-1:0]  mid_a,
  input logic [MID_N-1:0]  mid_b,
  input logic [LSB_BITS-1:0] lsb_a,
  input logic [LSB_BITS-1:0] lsb_b,
  input logic              out_valid
);
  localparam int UP_W  = 1 << (MID_BITS + LSB_BITS);
  localparam int MID_W = 1 << LSB_BITS;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> code_out == $past(din));

  assert_up_therm_R3: assert property (@(posedge clk) disable iff (rst)
    ((up_a + 1'b1) & up_a) == '0);

  assert_mid_therm_R4: assert property (@(posedge clk) disable iff (rst)
    ((mid_a + 1'b1) & mid_a) == '0);

  assert_weight_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (UP_W * $countones(up_a) + MID_W * $countones(mid_a)
                   + int'(lsb_a)) == int'($past(code_out)));

  assert_complement_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (up_b == ~up_a) && (mid_b == ~mid_a) && (lsb_b == ~lsb_a));

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(up_a) == int'($past(code_out[CODE_W-1 -: UP_BITS])));

  assert_sleep_park_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(code_out) && up_a == '0 && up_b == '0 && mid_a == '0
              && mid_b == '0 && lsb_a == '0 && lsb_b == '0 && !out_valid);
endmodule

bind segdac_switch_decoder segdac_checker #(
  .UP_BITS(UP_BITS), .MID_BITS(MID_BITS), .LSB_BITS(LSB_BITS)
) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .din(din), .code_out(code_out),
  .up_a(up_a), .up_b(up_b), .mid_a(mid_a), .mid_b(mid_b),
  .lsb_a(lsb_a), .lsb_b(lsb_b), .out_valid(out_valid)
);

// File: tb/segdac_switch_decoder_bench.sv
module segdac_switch_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep = 1'b0;
  logic [9:0]  din = '0;
  logic [9:0]  code_out;
  logic [30:0] up_a, up_b;
  logic [14:0] mid_a, mid_b;
  logic [0:0]  lsb_a, lsb_b;
  logic        out_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  segdac_switch_decoder u_segdac_switch_decoder (
    .clk(clk), .rst(rst), .sleep(sleep), .din(din), .code_out(code_out),
    .up_a(up_a), .up_b(up_b), .mid_a(mid_a), .mid_b(mid_b),
    .lsb_a(lsb_a), .lsb_b(lsb_b), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] exp_up(input int c);
    return 31'((64'd1 << (c >> 5)) - 64'd1);
  endfunction

  function automatic logic [14:0] exp_mid(input int c);
    return 15'((32'd1 << ((c >> 1) & 15)) - 32'd1);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_decode(input int c, input string tag);
    check(up_a == exp_up(c), {tag, " R3 up_a"}, up_a, exp_up(c));
    check(mid_a == exp_mid(c), {tag, " R4 mid_a"}, mid_a, exp_mid(c));
    check(lsb_a == 1'(c & 1), {tag, " R5 lsb_a"}, lsb_a, c & 1);
    check(up_b == ~exp_up(c) && mid_b == ~exp_mid(c) && lsb_b == ~1'(c & 1),
          {tag, " R7 complement"}, {up_b, mid_b, lsb_b},
          {~exp_up(c), ~exp_mid(c), ~1'(c & 1)});
  endtask

  initial begin
    int wt, wb;
    tick(3);
    check(code_out == 0, "R1 code_out in reset", code_out, 0);
    check(up_a == 0 && mid_a == 0 && lsb_a == 0, "R1 A side in reset",
          {up_a, mid_a, lsb_a}, 0);
    check(&{up_b, mid_b, lsb_b}, "R1 B side in reset", {up_b, mid_b, lsb_b},
          47'h7fff_ffff_ffff);
    check(!out_valid, "R1 valid in reset", out_valid, 0);

    din = 10'd37;
    rst = 1'b0;
    tick(1);
    check(!out_valid, "R11 valid after first edge", out_valid, 0);
    check(code_out == 10'd37, "R2 capture after reset", code_out, 37);
    check(up_a == 0 && &up_b, "R1 outputs decode reset code", up_a, 0);
    tick(1);
    check(out_valid, "R11 valid after second edge", out_valid, 1);
    check_decode(37, "R8 first code");

    for (int c = 0; c < 1024; c++) begin
      din = 10'(c);
      tick(1);
      check(code_out == 10'(c), "R2 capture sweep", code_out, c);
      tick(1);
      check_decode(c, "sweep");
      wt = 32 * $countones(up_a) + 2 * $countones(mid_a) + int'(lsb_a);
      wb = 32 * $countones(up_b) + 2 * $countones(mid_b) + int'(lsb_b);
      check(wt == c, "R6 A weight", wt, c);
      check(wb == 1023 - c, "R7 B weight", wb, 1023 - c);
    end

    din = 10'd1023;
    tick(2);
    check_decode(1023, "R8 full scale");
    din = 10'd0;
    tick(1);
    check_decode(1023, "R8 one edge latency");
    tick(1);
    check_decode(0, "R8 zero code");

    din = 10'd600;
    tick(2);
    sleep = 1'b1;
    din = 10'd77;
    tick(1);
    check(code_out == 10'd600, "R9 capture frozen", code_out, 600);
    check({up_a, up_b, mid_a, mid_b, lsb_a, lsb_b} == 0, "R9 all switches off",
          {up_a, mid_a, lsb_a}, 0);
    check(!out_valid, "R9 valid low", out_valid, 0);
    tick(3);
    check(code_out == 10'd600, "R9 still frozen", code_out, 600);
    check({up_a, up_b, mid_a, mid_b, lsb_a, lsb_b} == 0, "R9 still off",
          {up_b, mid_b, lsb_b}, 0);
    sleep = 1'b0;
    tick(1);
    check_decode(600, "R10 held code on release");
    check(code_out == 10'd77, "R10 new capture on release", code_out, 77);
    check(out_valid, "R10 valid on release", out_valid, 1);
    tick(1);
    check_decode(77, "R10 next code");

    rst = 1'b1;
    tick(1);
    check(code_out == 0 && up_a == 0 && &up_b && !out_valid,
          "R1 reset mid-run", {code_out, out_valid}, 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule